// File: doc/BRIEF.md
# Circular Bitmap Page Allocator

This block tracks which pages of a DMA mapping window are taken. It holds a bitmap in which bit k covers page k. A set bit marks page k as in use, and lower bits map to lower I/O virtual addresses. A client asks for a number of pages. The block rounds the request up to a power-of-two chunk of 8, 16, 32 or 64 bits, aligned to its own size.

The block searches for a chunk whose bits are all clear. The search is circular: it begins at a moving hint and examines one chunk per clock cycle. When it finds a free chunk it marks the whole chunk used and returns the chunk's first bit index. A separate free port clears a chunk that was handed out earlier and reports a misuse.

Each finished search writes the number of chunks it examined into a small ring of recent search lengths, which can be read back through an index port.

Top module: `page_bitmap_alloc`

## Requirements
- R1: After reset the map is empty, the hint is byte 0, and every status output is low. Every ring entry reads 0.
- R2: The chunk size is set by the page count: 1..8 pages take an aligned 8-bit chunk, 9..16 a 16-bit chunk, 17..32 a 32-bit chunk and 33..64 a 64-bit chunk. On success every bit of the chunk is set. `alloc_idx` is the chunk's byte offset times 8, so its low three bits are 0.
- R3: The search starts at the hint rounded down to the chunk's alignment (a multiple of 1, 2, 4 or 8 bytes). It walks upward one chunk per cycle. A chunk is taken only if all its bits are clear.
- R4: When the search passes the top of the map it continues from byte 0. On arriving back at its starting chunk without a hit it pulses `alloc_err_full`, and the map and hint stay unchanged.
- R5: After a success the hint becomes the byte just past the chunk. It becomes 0 when the chunk ends at the top of the map.
- R6: A request for 0 pages or for more than 64 pages pulses `alloc_err_size` one cycle after the request. `alloc_busy` stays low and nothing else changes.
- R7: An accepted request raises `alloc_busy` in the next cycle. Busy stays high until the cycle that shows `alloc_done` or `alloc_err_full`. Those two outputs never rise together. `alloc_req` is ignored while busy.
- R8: A free clears the aligned chunk that holds `free_idx`, with the chunk size given by `free_pages` as in R2, but only if every bit of that chunk is set. Otherwise, or when the page count is 0 or above 64, `free_err` pulses in the next cycle and the map is unchanged.
- R9: Each search that ends in success or in a full error writes the number of chunks it examined, including the last one, into the next ring slot. The ring has 256 slots and the write position wraps. `ring_rd_data` shows the slot selected by `ring_rd_idx` without a clock delay.
- R10: `alloc_done` is a single-cycle pulse. `alloc_idx` holds its value until the next success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Start an allocation (taken when not busy) |
| alloc_pages | input | 8 | Pages requested |
| alloc_busy | output | 1 | Search in progress |
| alloc_done | output | 1 | Allocation succeeded (one-cycle pulse) |
| alloc_idx | output | 9 | Bit index of the allocated chunk |
| alloc_err_size | output | 1 | Page count out of range (pulse) |
| alloc_err_full | output | 1 | No free chunk found (pulse) |
| free_req | input | 1 | Release a chunk |
| free_idx | input | 9 | Bit index inside the chunk to release |
| free_pages | input | 8 | Page count the chunk was allocated with |
| free_err | output | 1 | Release refused (pulse) |
| ring_rd_idx | input | 8 | Ring slot to read |
| ring_rd_data | output | 7 | Chunks examined by the search stored in that slot |

## Verification
The hardest situation to reach is a search that wraps. That needs a map with no free chunk between the hint and the top, and a single free chunk below the hint. The bench builds this state in steps:
- it fills the map one byte-chunk at a time until the block reports it full, which also drives the hint through the top of the map and back to 0;
- it releases byte 0;
- it asks for one page, which must come back at index 0 only after a wrap.

Rounding the hint down is reached by leaving the hint on an odd byte before asking for a 16-bit chunk. A bench model of the bitmap predicts each result and each ring entry.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [1:0] {
    CLS_B1 = 2'd0,
    CLS_B2 = 2'd1,
    CLS_B4 = 2'd2,
    CLS_B8 = 2'd3
  } chunk_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/pba_size_class.sv
module pba_size_class
  import pba_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] pages,
  output chunk_cls_e       cls,
  output logic             bad
);
  always_comb begin
    bad = (pages == '0) || (pages > CNT_W'(64));
    if (pages <= CNT_W'(8))       cls = CLS_B1;
    else if (pages <= CNT_W'(16)) cls = CLS_B2;
    else if (pages <= CNT_W'(32)) cls = CLS_B4;
    else                          cls = CLS_B8;
  end
endmodule

// File: rtl/pba_chunk_probe.sv
module pba_chunk_probe
  import pba_pkg::*;
#(
  parameter int MAP_BITS = 512,
  parameter int BYTE_W   = 6
) (
  input  logic [MAP_BITS-1:0] map,
  input  logic [BYTE_W-1:0]   byte_ptr,
  input  chunk_cls_e          cls,
  output logic [MAP_BITS-1:0] chunk_mask,
  output logic                all_clear,
  output logic                all_set
);
  localparam int BIT_W = BYTE_W + 3;

  logic [63:0]      lane;
  logic [BIT_W-1:0] base;

  always_comb begin
    case (cls)
      CLS_B1:  lane = 64'h0000_0000_0000_00FF;
      CLS_B2:  lane = 64'h0000_0000_0000_FFFF;
      CLS_B4:  lane = 64'h0000_0000_FFFF_FFFF;
      default: lane = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    base       = {byte_ptr, 3'b000};
    chunk_mask = MAP_BITS'(lane) << base;
    all_clear  = (map & chunk_mask) == '0;
    all_set    = (map & chunk_mask) == chunk_mask;
  end
endmodule

// File: rtl/pba_dur_ring.sv
module pba_dur_ring #(
  parameter int DEPTH = 256,
  parameter int DUR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DUR_W-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DUR_W-1:0]         rd_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DUR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (wr_en) begin
      slot_q[wp_q] <= wr_data;
      wp_q         <= wp_q + PTR_W'(1);
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/page_bitmap_alloc.sv
module page_bitmap_alloc
  import pba_pkg::*;
#(
  parameter int MAP_BITS   = 512,
  parameter int CNT_W      = 8,
  parameter int RING_DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_req,
  input  logic [CNT_W-1:0]              alloc_pages,
  output logic                          alloc_busy,
  output logic                          alloc_done,
  output logic [$clog2(MAP_BITS)-1:0]   alloc_idx,
  output logic                          alloc_err_size,
  output logic                          alloc_err_full,
  input  logic                          free_req,
  input  logic [$clog2(MAP_BITS)-1:0]   free_idx,
  input  logic [CNT_W-1:0]              free_pages,
  output logic                          free_err,
  input  logic [$clog2(RING_DEPTH)-1:0] ring_rd_idx,
  output logic [$clog2(MAP_BITS/8):0]   ring_rd_data
);
  localparam int MAP_BYTES = MAP_BITS / 8;
  localparam int BYTE_W    = $clog2(MAP_BYTES);
  localparam int BIT_W     = $clog2(MAP_BITS);
  localparam int DUR_W     = BYTE_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  // state
  scan_st_e           st_q, st_d;
  logic [MAP_BITS-1:0] map_q, map_d;
  logic [BYTE_W-1:0]  hint_q, hint_d, ptr_q, ptr_d, start_q, start_d;
  chunk_cls_e         cls_q, cls_d;
  logic               wrapped_q, wrapped_d;
  logic [DUR_W-1:0]   exam_q, exam_d, exam_now;
  logic               done_q, done_d, esize_q, esize_d, efull_q, efull_d;
  logic               ferr_q, ferr_d;
  logic [BIT_W-1:0]   idx_q, idx_d;

  // request decode
  chunk_cls_e         req_cls, fr_cls;
  logic               req_bad, fr_bad;
  logic [BYTE_W:0]    req_cb, cur_cb, fr_cb, ptr_adv;
  logic [BYTE_W-1:0]  start_calc, ptr_nxt, fr_byte;
  logic               at_end, wrap_now, exhausted;

  pba_size_class #(.CNT_W(CNT_W)) u_req_cls (
    .pages(alloc_pages), .cls(req_cls), .bad(req_bad));
  pba_size_class #(.CNT_W(CNT_W)) u_free_cls (
    .pages(free_pages), .cls(fr_cls), .bad(fr_bad));

  always_comb begin
    req_cb     = (BYTE_W+1)'(1) << req_cls;
    start_calc = hint_q & ~(BYTE_W'(req_cb) - BYTE_W'(1));
    cur_cb     = (BYTE_W+1)'(1) << cls_q;
    ptr_adv    = {1'b0, ptr_q} + cur_cb;
    at_end     = ptr_adv == (BYTE_W+1)'(MAP_BYTES);
    ptr_nxt    = at_end ? '0 : ptr_adv[BYTE_W-1:0];
    wrap_now   = wrapped_q | at_end;
    exhausted  = wrap_now && (ptr_nxt == start_q);
    fr_cb      = (BYTE_W+1)'(1) << fr_cls;
    fr_byte    = free_idx[BIT_W-1:3] & ~(BYTE_W'(fr_cb) - BYTE_W'(1));
    exam_now   = exam_q + DUR_W'(1);
  end

  // chunk probes: one for the search, one for releases
  logic [MAP_BITS-1:0] scan_mask, free_mask;
  logic                scan_clear, scan_full_unused, free_clear_unused, free_all_set;

  pba_chunk_probe #(.MAP_BITS(MAP_BITS), .BYTE_W(BYTE_W)) u_scan_probe (
    .map(map_q), .byte_ptr(ptr_q), .cls(cls_q),
    .chunk_mask(scan_mask), .all_clear(scan_clear), .all_set(scan_full_unused));
  pba_chunk_probe #(.MAP_BITS(MAP_BITS), .BYTE_W(BYTE_W)) u_free_probe (
    .map(map_q), .byte_ptr(fr_byte), .cls(fr_cls),
    .chunk_mask(free_mask), .all_clear(free_clear_unused), .all_set(free_all_set));

  logic                free_ok, ring_we;
  logic [MAP_BITS-1:0] set_mask, clr_mask;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    hint_d    = hint_q;
    ptr_d     = ptr_q;
    start_d   = start_q;
    cls_d     = cls_q;
    wrapped_d = wrapped_q;
    exam_d    = exam_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    esize_d   = 1'b0;
    efull_d   = 1'b0;
    ring_we   = 1'b0;
    set_mask  = '0;

    case (st_q)
      ST_IDLE: begin
        if (alloc_req) begin
          if (req_bad) begin
            esize_d = 1'b1;
          end else begin
            st_d      = ST_SCAN;
            ptr_d     = start_calc;
            start_d   = start_calc;
            cls_d     = req_cls;
            wrapped_d = 1'b0;
            exam_d    = '0;
          end
        end
      end
      default: begin
        if (scan_clear) begin
          set_mask = scan_mask;
          hint_d   = ptr_nxt;
          idx_d    = {ptr_q, 3'b000};
          done_d   = 1'b1;
          ring_we  = 1'b1;
          st_d     = ST_IDLE;
        end else if (exhausted) begin
          efull_d = 1'b1;
          ring_we = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          ptr_d     = ptr_nxt;
          wrapped_d = wrap_now;
          exam_d    = exam_now;
        end
      end
    endcase

    free_ok  = free_req && !fr_bad && free_all_set;
    ferr_d   = free_req && !free_ok;
    clr_mask = free_ok ? free_mask : '0;
    map_d    = (map_q & ~clr_mask) | set_mask;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q      <= ST_IDLE;
      map_q     <= '0;
      hint_q    <= '0;
      ptr_q     <= '0;
      start_q   <= '0;
      cls_q     <= CLS_B1;
      wrapped_q <= 1'b0;
      exam_q    <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
      esize_q   <= 1'b0;
      efull_q   <= 1'b0;
      ferr_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      map_q     <= map_d;
      hint_q    <= hint_d;
      ptr_q     <= ptr_d;
      start_q   <= start_d;
      cls_q     <= cls_d;
      wrapped_q <= wrapped_d;
      exam_q    <= exam_d;
      idx_q     <= idx_d;
      done_q    <= done_d;
      esize_q   <= esize_d;
      efull_q   <= efull_d;
      ferr_q    <= ferr_d;
    end
  end

  pba_dur_ring #(.DEPTH(RING_DEPTH), .DUR_W(DUR_W)) u_ring (
    .clk(clk), .rst_n(rst_i_n), .wr_en(ring_we), .wr_data(exam_now),
    .rd_idx(ring_rd_idx), .rd_data(ring_rd_data));

  assign alloc_busy     = (st_q == ST_SCAN);
  assign alloc_done     = done_q;
  assign alloc_idx      = idx_q;
  assign alloc_err_size = esize_q;
  assign alloc_err_full = efull_q;
  assign free_err       = ferr_q;
endmodule

// File: rtl/page_bitmap_alloc_chk.sv
module page_bitmap_alloc_chk #(
  parameter int CNT_W = 8,
  parameter int BIT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic [CNT_W-1:0] alloc_pages,
  input logic             alloc_busy,
  input logic             alloc_done,
  input logic [BIT_W-1:0] alloc_idx,
  input logic             alloc_err_size,
  input logic             alloc_err_full,
  input logic             free_req,
  input logic             free_err
);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> !alloc_busy);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_done, alloc_err_full, alloc_err_size}));

  assert_scan_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alloc_busy) |-> (alloc_done || alloc_err_full));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_busy && alloc_req && alloc_pages != '0 && alloc_pages <= CNT_W'(64))
      |=> alloc_busy);

  assert_size_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err_size |-> !alloc_busy);

  assert_idx_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> (alloc_idx[2:0] == 3'b000));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> !alloc_done);

  assert_idx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_done |-> $stable(alloc_idx));

  assert_free_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_err |-> $past(free_req));
endmodule

bind page_bitmap_alloc page_bitmap_alloc_chk #(.CNT_W(CNT_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .alloc_req(alloc_req), .alloc_pages(alloc_pages),
  .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_idx(alloc_idx),
  .alloc_err_size(alloc_err_size), .alloc_err_full(alloc_err_full),
  .free_req(free_req), .free_err(free_err));

// File: tb/page_bitmap_alloc_tb.sv
module page_bitmap_alloc_tb;
  localparam int NB = 512;
  localparam int NBY = NB / 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic [7:0] alloc_pages = '0;
  logic       alloc_busy, alloc_done, alloc_err_size, alloc_err_full, free_err;
  logic [8:0] alloc_idx;
  logic       free_req = 1'b0;
  logic [8:0] free_idx = '0;
  logic [7:0] free_pages = '0;
  logic [7:0] ring_rd_idx = '0;
  logic [6:0] ring_rd_data;

  always #4 clk = ~clk;

  page_bitmap_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_pages(alloc_pages),
    .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_idx(alloc_idx),
    .alloc_err_size(alloc_err_size), .alloc_err_full(alloc_err_full),
    .free_req(free_req), .free_idx(free_idx), .free_pages(free_pages),
    .free_err(free_err), .ring_rd_idx(ring_rd_idx), .ring_rd_data(ring_rd_data));

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  bit [NB-1:0] m_map;
  int          m_hint;
  int          exp_ring [256];
  int          ring_wp;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls_bytes(input int pages);
    if (pages <= 8) return 1;
    if (pages <= 16) return 2;
    if (pages <= 32) return 4;
    return 8;
  endfunction

  // status: 0 ok, 1 size error, 2 full
  function automatic void m_alloc(input int pages, output int idx, output int status,
                                  output int exam);
    int cb, start, p;
    bit wrapped, clear;
    idx = 0; exam = 0;
    if (pages == 0 || pages > 64) begin status = 1; return; end
    cb = cls_bytes(pages);
    start = m_hint - (m_hint % cb);
    p = start;
    wrapped = 0;
    while (1) begin
      exam++;
      clear = 1;
      for (int b = p * 8; b < (p + cb) * 8; b++) if (m_map[b]) clear = 0;
      if (clear) begin
        for (int b = p * 8; b < (p + cb) * 8; b++) m_map[b] = 1'b1;
        m_hint = (p + cb == NBY) ? 0 : p + cb;
        idx = p * 8; status = 0;
        exp_ring[ring_wp] = exam; ring_wp = (ring_wp + 1) % 256;
        return;
      end
      p = p + cb;
      if (p == NBY) begin p = 0; wrapped = 1; end
      if (wrapped && p == start) begin
        status = 2;
        exp_ring[ring_wp] = exam; ring_wp = (ring_wp + 1) % 256;
        return;
      end
    end
  endfunction

  function automatic bit m_free(input int idx, input int pages);
    int cb, fb;
    bit full;
    if (pages == 0 || pages > 64) return 1;
    cb = cls_bytes(pages);
    fb = (idx / 8) - ((idx / 8) % cb);
    full = 1;
    for (int b = fb * 8; b < (fb + cb) * 8; b++) if (!m_map[b]) full = 0;
    if (!full) return 1;
    for (int b = fb * 8; b < (fb + cb) * 8; b++) m_map[b] = 1'b0;
    return 0;
  endfunction

  // drive one request and wait for its outcome
  task automatic do_alloc(input int pages, output bit d, output bit es, output bit ef,
                          output int idx);
    d = 0; es = 0; ef = 0; idx = 0;
    @(negedge clk);
    alloc_req = 1'b1; alloc_pages = 8'(pages);
    @(negedge clk);
    alloc_req = 1'b0;
    for (int t = 0; t < 300; t++) begin
      if (alloc_done || alloc_err_size || alloc_err_full) begin
        d = alloc_done; es = alloc_err_size; ef = alloc_err_full; idx = int'(alloc_idx);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_alloc(input string req, input int pages, output int got_idx,
                           output int status);
    int eidx, est, eex, gidx;
    bit d, es, ef;
    m_alloc(pages, eidx, est, eex);
    do_alloc(pages, d, es, ef, gidx);
    got_idx = gidx;
    status = d ? 0 : (es ? 1 : (ef ? 2 : 3));
    chk(req, status == est, status, est);
    if (est == 0) chk(req, gidx == eidx, gidx, eidx);
  endtask

  task automatic do_free(input string req, input int idx, input int pages);
    bit eerr;
    eerr = m_free(idx, pages);
    @(negedge clk);
    free_req = 1'b1; free_idx = 9'(idx); free_pages = 8'(pages);
    @(negedge clk);
    free_req = 1'b0;
    chk(req, free_err == eerr, int'(free_err), int'(eerr));
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", alloc_busy == 0, int'(alloc_busy), 0);
    chk("R1 outputs after reset",
        {alloc_done, alloc_err_size, alloc_err_full, free_err} == 4'b0000,
        int'({alloc_done, alloc_err_size, alloc_err_full, free_err}), 0);
    ring_rd_idx = 8'd5; #1;
    chk("R1 ring cleared", ring_rd_data == 0, int'(ring_rd_data), 0);
  endtask

  // first search hits at once; a second request while busy must be dropped
  task automatic t_busy_ignore;
    int eidx, est, eex;
    m_alloc(1, eidx, est, eex);
    @(negedge clk);
    alloc_req = 1'b1; alloc_pages = 8'd1;
    @(negedge clk);
    chk("R7 busy after accept", alloc_busy == 1, int'(alloc_busy), 1);
    alloc_pages = 8'd2;
    @(negedge clk);
    alloc_req = 1'b0;
    chk("R7 done after one chunk", alloc_done == 1, int'(alloc_done), 1);
    chk("R7 busy low on done", alloc_busy == 0, int'(alloc_busy), 0);
    chk("R2 first index", alloc_idx == 9'd0, int'(alloc_idx), 0);
    @(negedge clk);
    chk("R10 done single pulse", alloc_done == 0, int'(alloc_done), 0);
    chk("R7 request while busy ignored", alloc_busy == 0, int'(alloc_busy), 0);
    chk("R10 index held", alloc_idx == 9'd0, int'(alloc_idx), 0);
  endtask

  task automatic t_classes;
    int g, s;
    run_alloc("R2 8-page class", 8, g, s);
    chk("R2 8 pages at byte 1", g == 8, g, 8);
    run_alloc("R2 16-bit class", 9, g, s);
    chk("R2 9 pages at 16", g == 16, g, 16);
    run_alloc("R2 32-bit class", 17, g, s);
    chk("R2 17 pages at 32", g == 32, g, 32);
    run_alloc("R2 64-bit class", 33, g, s);
    chk("R2 33 pages at 64", g == 64, g, 64);
    run_alloc("R5 hint past chunk", 3, g, s);
    chk("R5 3 pages at 128", g == 128, g, 128);
    run_alloc("R3 hint rounded down", 9, g, s);
    chk("R3 aligned start skips busy chunk", g == 144, g, 144);
  endtask

  task automatic t_size_err;
    int g, s;
    run_alloc("R6 zero pages", 0, g, s);
    run_alloc("R6 65 pages", 65, g, s);
    chk("R6 no busy on size error", alloc_busy == 0, int'(alloc_busy), 0);
    run_alloc("R6 state unchanged after size error", 1, g, s);
    chk("R6 next result follows hint", g == 160, g, 160);
  endtask

  task automatic t_free;
    int g, s;
    do_free("R8 free held chunk", 8, 8);
    do_free("R8 double free refused", 8, 8);
    do_free("R8 zero count refused", 16, 0);
    do_free("R8 count above 64 refused", 16, 70);
    do_free("R8 free 64-bit chunk", 64, 40);
    run_alloc("R3 search from hint not from zero", 1, g, s);
    chk("R3 freed low byte not chosen", g == 168, g, 168);
  endtask

  task automatic t_fill_wrap;
    int g, s;
    s = 0;
    for (int k = 0; k < 80 && s != 2; k++) run_alloc("R5 fill and hint wrap", 1, g, s);
    chk("R4 full reported", s == 2, s, 2);
    run_alloc("R4 full for 64-bit class", 40, g, s);
    do_free("R8 free byte 0", 0, 8);
    run_alloc("R4 wrap finds byte 0", 1, g, s);
    chk("R4 wrapped result", g == 0 && s == 0, g, 0);
    run_alloc("R4 full again", 1, g, s);
  endtask

  task automatic t_ring;
    for (int k = 1; k <= 6; k++) begin
      int slot;
      slot = (ring_wp - k + 256) % 256;
      ring_rd_idx = 8'(slot); #1;
      chk("R9 ring entry", int'(ring_rd_data) == exp_ring[slot], int'(ring_rd_data),
          exp_ring[slot]);
    end
    ring_rd_idx = 8'(ring_wp); #1;
    chk("R9 unwritten slot", ring_rd_data == 0, int'(ring_rd_data), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_map = '0; m_hint = 0; ring_wp = 0;
    for (int i = 0; i < 256; i++) exp_ring[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_busy_ignore();
    t_classes();
    t_size_err();
    t_free();
    t_fill_wrap();
    t_ring();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule